// File: doc/BRIEF.md
# Flash Write-Cycle Protection Gate

This block sits at the pin side of a parallel flash command interface and decides whether the chip-enable, write-enable and output-enable strobes form a real write cycle. It passes on only the cycles that pass its checks. The three active-low strobes are oversampled by a fast system clock. Each strobe goes through a two-flop synchroniser and then a persistence filter, so a level change counts only after it has been held for `GLITCH_CYCLES` consecutive samples. Short noise pulses therefore never reach the command logic.

The gate also enforces three other protections. A pin-level inhibit blocks any combination other than chip-enable low, write-enable low and output-enable high. A supply-lockout input blocks all writes and drives the downstream state machine back to read mode. An arming rule ignores a write that was already on the pins when power came up or when lockout ended. For each accepted cycle the gate produces two one-cycle pulses: a capture enable when the cycle opens and a write strobe when write-enable rises to close it.

Top module: `flash_wr_guard`

## Requirements
- R1: A cycle is valid only while the filtered levels are chip-enable low, write-enable low and output-enable high. When an armed gate enters a valid cycle, capEn goes high for exactly one clock.
- R2: wrStrobe goes high for exactly one clock when filtered write-enable rises and so ends a valid cycle that was entered while the gate was armed.
- R3: While output-enable is low, or chip-enable is high, no write-enable activity produces capEn or wrStrobe.
- R4: A strobe level held for fewer than GLITCH_CYCLES consecutive samples is ignored. A level held for exactly GLITCH_CYCLES samples is accepted. A steady pin change shows on capEn or wrStrobe at the (GLITCH_CYCLES+3)th rising clock edge after it.
- R5: While lockout is 1, capEn and wrStrobe stay low and forceRead is 1 from the next edge on. forceRead returns to 0 at the first edge after lockout clears.
- R6: After lockout clears, a write cycle that is still on the pins is discarded. Writes are accepted again only after the filtered pins have shown a non-write state.
- R7: forceRead is 1 while porN is low and remains 1 until the first rising edge after porN goes high.
- R8: If the pins hold a write cycle while porN is released, the write-enable rise that ends that cycle produces no wrStrobe. The next complete cycle is accepted.
- R9: capEn and wrStrobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| lockout | input | 1 | 1 while the supply is below the lockout level (synchronous to clk) |
| ceN | input | 1 | Chip-enable pin, active low |
| weN | input | 1 | Write-enable pin, active low |
| oeN | input | 1 | Output-enable pin, active low |
| wrStrobe | output | 1 | One-clock qualified write pulse |
| capEn | output | 1 | One-clock address/data capture enable at cycle start |
| forceRead | output | 1 | Forces the downstream state machine to read mode |

## Verification
The bench targets pulses one sample shorter than the filter threshold and pulses exactly at it. A filter that is off by one either lets noise start a cycle or drops a legitimate minimum-width write. It holds a write on the pins across reset release and across lockout exit. A gate without the arming rule would emit a spurious strobe on the trailing write-enable rise. It also steps through each inhibit combination and measures the exact output latency, so a missing synchroniser stage or a mistimed forceRead release would show up as a one-cycle mismatch against the reference model.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int NUM_PINS = 3;
  // bit order {oeN, weN, ceN}; this value is the one pin state that forms a write
  localparam logic [NUM_PINS-1:0] WRITE_LVL = 3'b100;

  typedef struct packed {
    logic oeN;
    logic weN;
    logic ceN;
  } pinLvlT;
endpackage

// File: rtl/wg_pin_filter.sv
module wg_pin_filter
  import wg_pkg::*;
#(
  parameter int GLITCH_CYCLES = 3
) (
  input  logic                clk,
  input  logic                porN,
  input  logic [NUM_PINS-1:0] rawPins,
  output pinLvlT              lvl
);
  localparam int CW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [NUM_PINS-1:0] metaQ, syncQ, filtQ;

  // Synchroniser resets to the write state so that a write present at power-up
  // appears continuous rather than as a fresh falling edge.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      metaQ <= WRITE_LVL;
      syncQ <= WRITE_LVL;
    end else begin
      metaQ <= rawPins;
      syncQ <= metaQ;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CW-1:0] runCnt;
    logic          levelQ;

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        runCnt <= '0;
        levelQ <= WRITE_LVL[i];
      end else if (syncQ[i] == levelQ) begin
        runCnt <= '0;
      end else if (runCnt == LAST) begin
        levelQ <= syncQ[i];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end

    assign filtQ[i] = levelQ;
  end

  assign lvl = pinLvlT'(filtQ);
endmodule

// File: rtl/wg_control.sv
module wg_control
  import wg_pkg::*;
(
  input  logic   clk,
  input  logic   porN,
  input  logic   lockout,
  input  pinLvlT lvl,
  output logic   wrStrobe,
  output logic   capEn,
  output logic   forceRead
);
  logic validNow, validPrev, armed;

  assign validNow = !lvl.ceN && !lvl.weN && lvl.oeN;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      validPrev <= 1'b1;
      armed     <= 1'b0;
      capEn     <= 1'b0;
      wrStrobe  <= 1'b0;
      forceRead <= 1'b1;
    end else begin
      validPrev <= validNow;
      armed     <= lockout ? 1'b0 : (armed || !validNow);
      capEn     <= !lockout && armed && validNow && !validPrev;
      wrStrobe  <= !lockout && armed && validPrev && !validNow && lvl.weN;
      forceRead <= lockout;
    end
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import wg_pkg::*;
#(
  parameter int GLITCH_CYCLES = 3
) (
  input  logic clk,
  input  logic porN,
  input  logic lockout,
  input  logic ceN,
  input  logic weN,
  input  logic oeN,
  output logic wrStrobe,
  output logic capEn,
  output logic forceRead
);
  pinLvlT pinLvl;

  wg_pin_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filter (
    .clk     (clk),
    .porN    (porN),
    .rawPins ({oeN, weN, ceN}),
    .lvl     (pinLvl)
  );

  wg_control u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .lockout   (lockout),
    .lvl       (pinLvl),
    .wrStrobe  (wrStrobe),
    .capEn     (capEn),
    .forceRead (forceRead)
  );
endmodule

// File: rtl/wg_checker.sv
module wg_checker (
  input logic clk,
  input logic porN,
  input logic lockout,
  input logic wrStrobe,
  input logic capEn,
  input logic forceRead
);
  assert_cap_single_R1: assert property (@(posedge clk) disable iff (!porN)
    capEn |=> !capEn);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!porN)
    wrStrobe |=> !wrStrobe);

  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!porN)
    lockout |=> (!wrStrobe && !capEn && forceRead));

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!porN)
    !lockout |=> !forceRead);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!porN)
    !(capEn && wrStrobe));
endmodule

bind flash_wr_guard wg_checker u_chk (
  .clk       (clk),
  .porN      (porN),
  .lockout   (lockout),
  .wrStrobe  (wrStrobe),
  .capEn     (capEn),
  .forceRead (forceRead)
);

// File: tb/sim_flash_wr_guard.sv
`timescale 1ns/1ps
module sim_flash_wr_guard;
  localparam int G = 3;

  logic clk = 1'b0;
  logic porN, lockout, ceN, weN, oeN;
  logic wrStrobe, capEn, forceRead;
  int checks = 0, failures = 0, nCap = 0, nStr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wr_guard #(.GLITCH_CYCLES(G)) u0 (
    .clk(clk), .porN(porN), .lockout(lockout), .ceN(ceN), .weN(weN), .oeN(oeN),
    .wrStrobe(wrStrobe), .capEn(capEn), .forceRead(forceRead)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pin sample history, levels accepted after G equal samples
  bit [2:0] p1, p2, lvl;
  bit [2:0] hist[$];
  bit prevV, arm, eCap, eStr, eFr;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      p1 = 3'b100; p2 = 3'b100; lvl = 3'b100; hist.delete();
      prevV = 1; arm = 0; eCap = 0; eStr = 0; eFr = 1;
    end else begin
      bit v;
      v = (lvl == 3'b100);
      eCap = !lockout && arm && v && !prevV;
      eStr = !lockout && arm && prevV && !v && lvl[1];
      eFr = lockout;
      arm = lockout ? 1'b0 : (arm || !v);
      prevV = v;
      hist.push_back(p2);
      if (hist.size() > G) void'(hist.pop_front());
      if (hist.size() == G) begin
        for (int i = 0; i < 3; i++) begin
          bit allNew;
          allNew = 1'b1;
          foreach (hist[j]) if (hist[j][i] == lvl[i]) allNew = 1'b0;
          if (allNew) lvl[i] = ~lvl[i];
        end
      end
      p2 = p1;
      p1 = {oeN, weN, ceN};
    end
  end

  always @(negedge clk) begin
    if (porN && !done) begin
      chk(capEn == eCap, "R1 capEn vs model", capEn, eCap);
      chk(wrStrobe == eStr, "R2 wrStrobe vs model", wrStrobe, eStr);
      chk(forceRead == eFr, "R5 forceRead vs model", forceRead, eFr);
      if (capEn) nCap++;
      if (wrStrobe) nStr++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input int lowLen, input bit oeLvl, input bit ceLvl);
    ceN = ceLvl; oeN = oeLvl; wt(8);
    weN = 1'b0; wt(lowLen);
    weN = 1'b1; wt(8);
    ceN = 1'b1; oeN = 1'b1; wt(12);
  endtask

  task automatic counts(input string tag, input int eC, input int eS);
    chk(nCap == eC, {tag, " capEn count"}, nCap, eC);
    chk(nStr == eS, {tag, " wrStrobe count"}, nStr, eS);
    nCap = 0; nStr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    porN = 1'b0; lockout = 1'b0; ceN = 1'b0; weN = 1'b0; oeN = 1'b1;
    wt(4);
    chk(forceRead == 1'b1, "R7 forceRead in reset", forceRead, 1);
    porN = 1'b1;
    wt(1);
    chk(forceRead == 1'b0, "R7 forceRead after first edge", forceRead, 0);
    wt(10); nCap = 0; nStr = 0;
    // R8: write held through power-up, then ended
    weN = 1'b1; wt(12); ceN = 1'b1; wt(12);
    counts("R8 power-up write", 0, 0);
    doWrite(5, 1'b1, 1'b0);
    counts("R8 R1 R2 next write", 1, 1);
    // R4 latency of a steady change
    ceN = 1'b0; oeN = 1'b1; wt(12);
    weN = 1'b0;
    repeat (G + 2) @(posedge clk);
    @(negedge clk);
    chk(capEn == 1'b0, "R4 capEn one edge early", capEn, 0);
    @(posedge clk); @(negedge clk);
    chk(capEn == 1'b1, "R4 capEn at G+3 edges", capEn, 1);
    wt(4); weN = 1'b1; wt(12); ceN = 1'b1; wt(12);
    nCap = 0; nStr = 0;
    // R4 glitch below and at threshold
    doWrite(G - 1, 1'b1, 1'b0);
    counts("R4 short pulse", 0, 0);
    doWrite(G, 1'b1, 1'b0);
    counts("R4 threshold pulse", 1, 1);
    // R3 inhibits
    doWrite(6, 1'b0, 1'b0);
    counts("R3 oe low", 0, 0);
    doWrite(6, 1'b1, 1'b1);
    counts("R3 ce high", 0, 0);
    // R5 lockout
    lockout = 1'b1; wt(2);
    chk(forceRead == 1'b1, "R5 forceRead in lockout", forceRead, 1);
    doWrite(6, 1'b1, 1'b0);
    counts("R5 write in lockout", 0, 0);
    lockout = 1'b0; wt(2);
    chk(forceRead == 1'b0, "R5 forceRead after lockout", forceRead, 0);
    doWrite(6, 1'b1, 1'b0);
    counts("R5 write after lockout", 1, 1);
    // R6 write straddling lockout exit
    ceN = 1'b0; oeN = 1'b1; wt(12);
    weN = 1'b0; wt(12);
    lockout = 1'b1; wt(4); lockout = 1'b0; wt(4);
    weN = 1'b1; wt(12); ceN = 1'b1; wt(12);
    counts("R6 straddling write", 1, 0);
    doWrite(6, 1'b1, 1'b0);
    counts("R6 R9 rearmed write", 1, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule